// File: doc/BRIEF.md
# Pipe Buffer-Ready Interrupt Controller

This block keeps buffer-ready state for a group of USB endpoint pipes and raises one summary interrupt. The packet engine reports, per pipe, when a packet arrives (with a flag for a short or zero-length packet) and when a packet has been sent. The CPU side reports when a receive buffer has been read out or when transmit data has been committed. Each pipe carries a direction bit, a transfer-end mode bit and a transaction counter with its own enable and programmed count.

For every pipe the block holds a buffer-status flag (the buffer is ready for CPU access) and an interrupt status bit that software clears by writing zero. A summary flag gathers the enabled status bits. A global mode input picks when the summary drops: when software has cleared every enabled status bit, or only once every buffer-status flag is also clear. Readiness comes only from packet-arrival and packet-sent events, never from a handshake, so isochronous pipes work the same way as the others.

Top module: `pipe_ready_irq`

## Requirements
- R1: While reset is low, sts, bsts, summary and irq are all zero.
- R2: On a pipe with pipe_is_tx[i]=1, tx_sent[i] while bsts[i]=0 sets bsts[i] and sts[i] on the next clock edge. While bsts[i]=1, tx_sent[i] is ignored.
- R3: On a pipe with pipe_is_tx[i]=0 and end_mode[i]=0, rx_pkt[i] while bsts[i]=0 sets bsts[i] and sts[i] on the next edge. This includes a zero-length packet (rx_short[i]=1).
- R4: On a receive pipe, rx_pkt[i] while bsts[i]=1 (unread data) changes neither bsts[i] nor sts[i].
- R5: With end_mode[i]=1, a packet that is accepted but does not end the transfer sets bsts[i] and leaves sts[i] unchanged. A short packet ends the transfer and sets sts[i].
- R6: With trn_en[i]=1, the counter loads trn_cfg[i*CNTW +: CNTW] on the rising edge of trn_en[i]. It counts accepted packets, and the packet that brings it to its last count ends the transfer. It reloads after each end. With trn_en[i]=0 the counter has no effect.
- R7: On a receive pipe, cpu_rd_done[i] clears bsts[i]; on a transmit pipe, cpu_wr_done[i] clears it. The strobe of the other direction has no effect, and rx_pkt has no effect on a transmit pipe.
- R8: When sts_we=1, a 0 in sts_wdata[i] clears sts[i] and a 1 keeps it. A set event on the same edge wins over the clear.
- R9: With clr_mode=0, summary is 1 exactly when some sts[i] with pipe_ie[i]=1 is set.
- R10: With clr_mode=1, once set, summary stays 1 until the enabled status bits are clear and every bsts bit is 0.
- R11: irq is summary gated by irq_en with no clock delay. A pipe with pipe_ie[i]=0 does not hold summary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_is_tx | input | NPIPE | 1 = transmit pipe, 0 = receive pipe |
| end_mode | input | NPIPE | Receive pipes: raise status only at transfer end |
| trn_en | input | NPIPE | Transaction counter enable |
| trn_cfg | input | NPIPE*CNTW | Programmed packet count per pipe, pipe i at bits i*CNTW |
| rx_pkt | input | NPIPE | Packet received (one-cycle pulse) |
| rx_short | input | NPIPE | The received packet is short or zero-length |
| tx_sent | input | NPIPE | Packet sent, buffer free for writing |
| cpu_rd_done | input | NPIPE | CPU finished reading a receive buffer |
| cpu_wr_done | input | NPIPE | CPU committed data in a transmit buffer |
| sts_we | input | 1 | Status write strobe |
| sts_wdata | input | NPIPE | Status write data, 0 clears, 1 keeps |
| pipe_ie | input | NPIPE | Per-pipe enable into the summary |
| irq_en | input | 1 | Global interrupt enable |
| clr_mode | input | 1 | Summary clear rule select |
| sts | output | NPIPE | Per-pipe interrupt status |
| bsts | output | NPIPE | Per-pipe buffer-ready flag |
| summary | output | 1 | Summary flag |
| irq | output | 1 | Interrupt output |

## Verification
The hardest state to reach is a transfer that ends on the counter in transfer-end mode, because every accepted packet has to be read out before the next one counts. The stimulus enables the counter, then alternates packet and read-done strobes three times, and only the third packet may raise status. The bench then checks that the counter reloaded and that it has no effect once disabled. Holding the summary in the second clear mode is reached by clearing the status while buffers are still full, then emptying them one at a time.

// File: rtl/pipe_ready_irq.sv
module pipe_ready_irq #(
  parameter int NPIPE = 8,
  parameter int CNTW  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPIPE-1:0]      pipe_is_tx,
  input  logic [NPIPE-1:0]      end_mode,
  input  logic [NPIPE-1:0]      trn_en,
  input  logic [NPIPE*CNTW-1:0] trn_cfg,
  input  logic [NPIPE-1:0]      rx_pkt,
  input  logic [NPIPE-1:0]      rx_short,
  input  logic [NPIPE-1:0]      tx_sent,
  input  logic [NPIPE-1:0]      cpu_rd_done,
  input  logic [NPIPE-1:0]      cpu_wr_done,
  input  logic                  sts_we,
  input  logic [NPIPE-1:0]      sts_wdata,
  input  logic [NPIPE-1:0]      pipe_ie,
  input  logic                  irq_en,
  input  logic                  clr_mode,
  output logic [NPIPE-1:0]      sts,
  output logic [NPIPE-1:0]      bsts,
  output logic                  summary,
  output logic                  irq
);
  localparam logic [CNTW-1:0] LAST = CNTW'(1);

  logic [NPIPE-1:0] sts_q, bsts_q, sts_n, bsts_n;
  logic [NPIPE-1:0] acc_rx, acc_tx, end_ev, set_ev, clr_ev, en_q;
  logic [NPIPE-1:0] wclr;
  logic             summ_q, summ_n;

  assign wclr = sts_we ? ~sts_wdata : '0;

  for (genvar i = 0; i < NPIPE; i++) begin : g_pipe
    logic [CNTW-1:0] cnt_q;
    logic [CNTW-1:0] cfg;

    assign cfg       = trn_cfg[i*CNTW +: CNTW];
    assign acc_rx[i] = ~pipe_is_tx[i] & rx_pkt[i] & ~bsts_q[i];
    assign acc_tx[i] =  pipe_is_tx[i] & tx_sent[i] & ~bsts_q[i];
    assign end_ev[i] = rx_short[i] | (trn_en[i] & en_q[i] & (cnt_q == LAST));
    assign set_ev[i] = acc_tx[i] | (acc_rx[i] & (~end_mode[i] | end_ev[i]));
    assign clr_ev[i] = bsts_q[i] & (pipe_is_tx[i] ? cpu_wr_done[i] : cpu_rd_done[i]);
    assign bsts_n[i] = (acc_rx[i] | acc_tx[i]) ? 1'b1 : (clr_ev[i] ? 1'b0 : bsts_q[i]);
    assign sts_n[i]  = (sts_q[i] & ~wclr[i]) | set_ev[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q   <= '0;
        en_q[i] <= 1'b0;
      end else begin
        en_q[i] <= trn_en[i];
        if (trn_en[i] && !en_q[i])
          cnt_q <= cfg;
        else if (trn_en[i] && acc_rx[i])
          cnt_q <= end_ev[i] ? cfg : cnt_q - LAST;
      end
    end
  end

  assign summ_n = |(sts_n & pipe_ie) | (clr_mode & summ_q & |bsts_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q  <= '0;
      bsts_q <= '0;
      summ_q <= 1'b0;
    end else begin
      sts_q  <= sts_n;
      bsts_q <= bsts_n;
      summ_q <= summ_n;
    end
  end

  assign sts     = sts_q;
  assign bsts    = bsts_q;
  assign summary = summ_q;
  assign irq     = summ_q & irq_en;
endmodule

// File: rtl/pipe_ready_irq_chk.sv
module pipe_ready_irq_chk #(
  parameter int NPIPE = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPIPE-1:0] pipe_is_tx,
  input logic [NPIPE-1:0] rx_pkt,
  input logic [NPIPE-1:0] tx_sent,
  input logic [NPIPE-1:0] cpu_rd_done,
  input logic             sts_we,
  input logic [NPIPE-1:0] sts_wdata,
  input logic [NPIPE-1:0] pipe_ie,
  input logic             clr_mode,
  input logic [NPIPE-1:0] sts,
  input logic [NPIPE-1:0] bsts,
  input logic             summary
);
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |-> (sts == '0 && bsts == '0 && !summary));

  a_r9_clear_rule: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(summary) |-> ((sts & $past(pipe_ie)) == '0));

  a_r10_mode1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(summary) && $past(clr_mode)) |-> (bsts == '0));

  for (genvar i = 0; i < NPIPE; i++) begin : g_chk
    a_r2_tx_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (pipe_is_tx[i] && tx_sent[i] && !bsts[i]) |=> (bsts[i] && sts[i]));

    a_r4_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      (!pipe_is_tx[i] && bsts[i] && rx_pkt[i] && !cpu_rd_done[i] && !(sts_we && !sts_wdata[i]))
      |=> (bsts[i] && sts[i] == $past(sts[i])));

    a_r8_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (sts[i] && !(sts_we && !sts_wdata[i])) |=> sts[i]);
  end
endmodule

bind pipe_ready_irq pipe_ready_irq_chk #(.NPIPE(NPIPE)) u_chk (
  .clk(clk), .rst_n(rst_n), .pipe_is_tx(pipe_is_tx), .rx_pkt(rx_pkt),
  .tx_sent(tx_sent), .cpu_rd_done(cpu_rd_done), .sts_we(sts_we),
  .sts_wdata(sts_wdata), .pipe_ie(pipe_ie), .clr_mode(clr_mode),
  .sts(sts), .bsts(bsts), .summary(summary)
);

// File: tb/sim_pipe_ready_irq.sv
module sim_pipe_ready_irq;
  localparam int N = 8;
  localparam int W = 8;
  localparam time TCLK = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] pipe_is_tx = 8'h0F, end_mode = '0, trn_en = '0;
  logic [N*W-1:0] trn_cfg = {N{8'd3}};
  logic [N-1:0] rx_pkt = '0, rx_short = '0, tx_sent = '0, cpu_rd_done = '0, cpu_wr_done = '0;
  logic sts_we = 1'b0;
  logic [N-1:0] sts_wdata = '1, pipe_ie = '1;
  logic irq_en = 1'b1, clr_mode = 1'b0;
  logic [N-1:0] sts, bsts;
  logic summary, irq;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  typedef struct { logic [N-1:0] s; logic [N-1:0] b; logic i; string tag; } exp_t;
  exp_t q[$];
  exp_t e;

  always #(TCLK/2) clk = ~clk;

  pipe_ready_irq #(.NPIPE(N), .CNTW(W)) u0 (
    .clk(clk), .rst_n(rst_n), .pipe_is_tx(pipe_is_tx), .end_mode(end_mode),
    .trn_en(trn_en), .trn_cfg(trn_cfg), .rx_pkt(rx_pkt), .rx_short(rx_short),
    .tx_sent(tx_sent), .cpu_rd_done(cpu_rd_done), .cpu_wr_done(cpu_wr_done),
    .sts_we(sts_we), .sts_wdata(sts_wdata), .pipe_ie(pipe_ie), .irq_en(irq_en),
    .clr_mode(clr_mode), .sts(sts), .bsts(bsts), .summary(summary), .irq(irq)
  );

  task automatic step(input logic [N-1:0] rxp, input logic [N-1:0] rxs,
                      input logic [N-1:0] txs, input logic [N-1:0] rdd,
                      input logic [N-1:0] wrd, input logic we, input logic [N-1:0] wd,
                      input logic ien, input logic [N-1:0] es, input logic [N-1:0] eb,
                      input logic ei, input string tag);
    exp_t x;
    @(negedge clk); #2;
    rx_pkt = rxp; rx_short = rxs; tx_sent = txs; cpu_rd_done = rdd;
    cpu_wr_done = wrd; sts_we = we; sts_wdata = wd; irq_en = ien;
    @(posedge clk); #1;
    rx_pkt = '0; rx_short = '0; tx_sent = '0; cpu_rd_done = '0;
    cpu_wr_done = '0; sts_we = 1'b0; sts_wdata = '1;
    x.s = es; x.b = eb; x.i = ei; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic idle(input logic ien, input logic [N-1:0] es, input logic [N-1:0] eb,
                      input logic ei, input string tag);
    step('0, '0, '0, '0, '0, 1'b0, '1, ien, es, eb, ei, tag);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        e = q.pop_front();
        n_cmp++;
        if (sts !== e.s || bsts !== e.b || irq !== e.i) begin
          n_bad++;
          $display("FAIL %s: actual sts=%h bsts=%h irq=%b expected sts=%h bsts=%h irq=%b",
                   e.tag, sts, bsts, irq, e.s, e.b, e.i);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    n_cmp++;
    if (sts !== '0 || bsts !== '0 || summary !== 1'b0 || irq !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 in reset: actual sts=%h bsts=%h sum=%b irq=%b expected all zero",
               sts, bsts, summary, irq);
    end
    #1 rst_n = 1'b1;
    idle(1, 8'h00, 8'h00, 0, "R1 after reset");
    step('0, '0, 8'h01, '0, '0, 0, '1, 1, 8'h01, 8'h01, 1, "R2 tx ready");
    step('0, '0, 8'h01, '0, '0, 0, '1, 1, 8'h01, 8'h01, 1, "R2 tx busy ignored");
    step(8'h10, 8'h10, '0, '0, '0, 0, '1, 1, 8'h11, 8'h11, 1, "R3 zero-length rx");
    step(8'h10, '0, '0, '0, '0, 0, '1, 1, 8'h11, 8'h11, 1, "R4 unread ignored");
    step(8'h01, '0, '0, '0, '0, 0, '1, 1, 8'h11, 8'h11, 1, "R7 rx on tx pipe");
    step('0, '0, '0, '0, '0, 1, 8'hFE, 1, 8'h10, 8'h11, 1, "R8 write zero clears");
    step('0, '0, '0, '0, '0, 1, 8'hFF, 1, 8'h10, 8'h11, 1, "R8 write one keeps");
    step('0, '0, '0, 8'h01, 8'h10, 0, '1, 1, 8'h10, 8'h11, 1, "R7 wrong strobe");
    step('0, '0, '0, 8'h10, '0, 0, '1, 1, 8'h10, 8'h01, 1, "R7 rd done");
    step(8'h10, '0, '0, '0, '0, 1, 8'hEF, 1, 8'h10, 8'h11, 1, "R8 set wins");
    step('0, '0, '0, '0, '0, 1, 8'hEF, 1, 8'h00, 8'h11, 0, "R9 mode0 clear");
    clr_mode = 1'b1;
    step(8'h20, '0, '0, '0, '0, 0, '1, 1, 8'h20, 8'h31, 1, "R10 set");
    step('0, '0, '0, '0, '0, 1, 8'hDF, 1, 8'h00, 8'h31, 1, "R10 held by bsts");
    step('0, '0, '0, 8'h10, 8'h01, 0, '1, 1, 8'h00, 8'h20, 1, "R10 still held");
    step('0, '0, '0, 8'h20, '0, 0, '1, 1, 8'h00, 8'h00, 0, "R10 released");
    clr_mode = 1'b0;
    step('0, '0, 8'h02, '0, '0, 0, '1, 0, 8'h02, 8'h02, 0, "R11 gated off");
    idle(1, 8'h02, 8'h02, 1, "R11 gate on");
    pipe_ie = 8'hFD;
    idle(1, 8'h02, 8'h02, 0, "R11 pipe masked");
    step('0, '0, '0, '0, 8'h02, 1, 8'hFD, 1, 8'h00, 8'h00, 0, "R11 clean");
    pipe_ie = 8'hFF;
    end_mode = 8'h40;
    step(8'h40, '0, '0, '0, '0, 0, '1, 1, 8'h00, 8'h40, 0, "R5 mid packet");
    step('0, '0, '0, 8'h40, '0, 0, '1, 1, 8'h00, 8'h00, 0, "R5 read");
    step(8'h40, 8'h40, '0, '0, '0, 0, '1, 1, 8'h40, 8'h40, 1, "R5 short ends");
    step('0, '0, '0, 8'h40, '0, 1, 8'hBF, 1, 8'h00, 8'h00, 0, "R5 clean");
    end_mode = 8'hC0;
    trn_en = 8'h80;
    idle(1, 8'h00, 8'h00, 0, "R6 load");
    for (int k = 0; k < 2; k++) begin
      step(8'h80, '0, '0, '0, '0, 0, '1, 1, 8'h00, 8'h80, 0, "R6 counting");
      step('0, '0, '0, 8'h80, '0, 0, '1, 1, 8'h00, 8'h00, 0, "R6 read");
    end
    step(8'h80, '0, '0, '0, '0, 0, '1, 1, 8'h80, 8'h80, 1, "R6 count ends");
    step('0, '0, '0, 8'h80, '0, 1, 8'h7F, 1, 8'h00, 8'h00, 0, "R6 clean");
    step(8'h80, '0, '0, '0, '0, 0, '1, 1, 8'h00, 8'h80, 0, "R6 reloaded");
    step('0, '0, '0, 8'h80, '0, 0, '1, 1, 8'h00, 8'h00, 0, "R6 read");
    trn_en = 8'h00;
    for (int k = 0; k < 2; k++) begin
      step(8'h80, '0, '0, '0, '0, 0, '1, 1, 8'h00, 8'h80, 0, "R6 disabled");
      step('0, '0, '0, 8'h80, '0, 0, '1, 1, 8'h00, 8'h00, 0, "R6 read");
    end
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule